// File: doc/BRIEF.md
# Oscillator Loss Supervisor

This block watches for loss of the main oscillator while the device sits in a low-power stop state, and decides what to do about it. Three configuration bits choose the response. The block can ignore the loss. It can request a clock-monitor reset at once. Or it can bring up a backup clock path (regulator, PLL, self-clock operation) and repeat an oscillator quality check until the oscillator is good again. The configuration is captured when stop is entered. Later changes to the configuration bits do not alter the response until the next stop entry.

An external clock monitor reports failures through `osc_fail`. Each oscillator period arrives as a one-cycle `osc_edge` strobe in the system clock domain. A wakeup event or an external reset ends the stop state. The system clock select then shows whether the device leaves stop on the oscillator or on the PLL. It leaves on the oscillator if the oscillator recovered while stopped, and on the PLL otherwise. A sticky flag records each fall-back. If the latched interrupt enable is set, the flag also raises an interrupt request, and that request wakes the device into self-clock operation.

All outputs are registered and change on the same clock edge as the internal state.

Top module: `osc_loss_supervisor`

## Requirements
- R1: After reset `vreg_en` is 1. `pll_en`, `scm_active`, `sysclk_pll`, `mon_rst_req`, `scm_flag` and `scm_irq` are 0.
- R2: If the latched monitor enable is 0, `osc_fail` during stop has no effect. No reset request is made, the flag is not set, and the regulator and PLL stay off.
- R3: If the latched monitor enable is 1 and the latched backup enable is 0, a failure in stop produces `mon_rst_req` for exactly one cycle. The block returns to run, with `vreg_en` 1.
- R4: If both latched enables are 1, a failure in stop sets `vreg_en`, `pll_en`, `scm_active` and `scm_flag` on the same edge. `sysclk_pll` stays 0.
- R5: `scm_irq` equals `scm_flag` AND the interrupt enable latched at stop entry. When `scm_irq` is 1 while stopped in self-clock operation, the block leaves stop on the next edge, with `sysclk_pll` 1.
- R6: With the interrupt enable latched 0, the block stays stopped in self-clock operation until `wake_evt` or `ext_rst`. Either one makes it leave stop with `sysclk_pll` 1 if the oscillator has not yet qualified.
- R7: The oscillator qualifies after QUAL_CYC `osc_edge` strobes with `osc_fail` low. A strobe cycle with `osc_fail` high restarts the count from zero.
- R8: If qualification completes while stopped, the next edge clears `pll_en` and `scm_active` while `vreg_en` stays 1. The edge after that clears `vreg_en`.
- R9: A `wake_evt` or `ext_rst` after recovery in stop returns to run on the oscillator: `vreg_en` 1, `pll_en` 0, `sysclk_pll` 0.
- R10: After leaving stop on the PLL, qualification returns the block to run. `sysclk_pll`, `pll_en` and `scm_active` fall on the edge after the last qualifying strobe.
- R11: `scm_flag` stays 1 until `flag_clr` is pulsed. A set and a clear in the same cycle leave it set.
- R12: The configuration bits are sampled only on the rising edge of `stop_mode`. Changing them during stop does not change the response to a failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mon_en | input | 1 | Enable clock-loss detection |
| cfg_scm_en | input | 1 | Fall back to backup clock instead of resetting |
| cfg_scm_ie | input | 1 | Let the fall-back flag raise an interrupt |
| osc_fail | input | 1 | Failure indication from the clock monitor |
| osc_edge | input | 1 | One-cycle strobe per oscillator period |
| stop_mode | input | 1 | Device is in low-power stop (rising edge = entry) |
| wake_evt | input | 1 | Wakeup event pulse |
| ext_rst | input | 1 | External reset pulse, ends stop |
| flag_clr | input | 1 | Write-one-to-clear pulse for the fall-back flag |
| mon_rst_req | output | 1 | One-cycle clock-monitor reset request |
| vreg_en | output | 1 | Regulator enable |
| pll_en | output | 1 | Backup PLL enable |
| scm_active | output | 1 | Self-clock operation active |
| scm_flag | output | 1 | Sticky fall-back flag |
| scm_irq | output | 1 | Fall-back interrupt request |
| sysclk_pll | output | 1 | 1 = system clock taken from PLL, 0 = oscillator |

## Verification
The hardest condition to reach is the exact qualification boundary. A failure arrives part-way through a check, and then the restarted count must complete while still stopped, so that the two-step power-down can be observed one edge apart. The bench reaches it by overriding QUAL_CYC to a small value. It then issues counted `osc_edge` strobes around one failure pulse and confirms that the PLL is still on after one strobe fewer than the full count. A sweep over all eight configuration combinations covers the response selection, and directed sequences cover exit on the oscillator and exit on the PLL.

// File: rtl/osc_loss_pkg.sv
package osc_loss_pkg;

  typedef enum logic [1:0] {
    RESP_NONE,
    RESP_RESET,
    RESP_BACKUP
  } resp_e;

  typedef enum logic [2:0] {
    S_RUN,       // normal operation on oscillator
    S_WATCH,     // stopped, oscillator assumed fine
    S_BK_STOP,   // stopped, backup clock path up, qualifying
    S_PLL_DOWN,  // stopped, oscillator qualified, PLL dropped
    S_QUIET,     // stopped, recovered, regulator dropped
    S_BK_RUN     // running on PLL, still qualifying
  } st_e;

  typedef struct packed {
    logic vreg;
    logic pll;
    logic scm;
    logic sel_pll;
  } drv_t;

  function automatic resp_e resp_of(logic mon, logic bk);
    if (!mon)    return RESP_NONE;
    else if (!bk) return RESP_RESET;
    else          return RESP_BACKUP;
  endfunction

  function automatic drv_t drive_of(st_e s);
    drv_t d;
    d = '0;
    case (s)
      S_RUN:      d.vreg = 1'b1;
      S_BK_STOP:  begin d.vreg = 1'b1; d.pll = 1'b1; d.scm = 1'b1; end
      S_PLL_DOWN: d.vreg = 1'b1;
      S_BK_RUN:   begin d.vreg = 1'b1; d.pll = 1'b1; d.scm = 1'b1; d.sel_pll = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/osc_qual_counter.sv
module osc_qual_counter #(
  parameter int QUAL_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic osc_edge,
  input  logic osc_fail,
  output logic done
);
  localparam int CW = (QUAL_CYC > 2) ? $clog2(QUAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (osc_fail) begin
        cnt_q <= '0;
      end else if (osc_edge) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done = done_q;

  // R7: qualification only follows a clean strobe while enabled
  a_r7_done_after_clean_edge: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(en && osc_edge && !osc_fail));

endmodule

// File: rtl/osc_loss_flag.sv
module osc_loss_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_q, irq_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & ie;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R11: the flag only drops on a clear request or reset
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(clr || rst));

endmodule

// File: rtl/osc_loss_fsm.sv
module osc_loss_fsm
  import osc_loss_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_mode,
  input  logic wake_evt,
  input  logic ext_rst,
  input  logic osc_fail,
  input  logic cfg_mon_en,
  input  logic cfg_scm_en,
  input  logic cfg_scm_ie,
  input  logic qual_done,
  input  logic irq_in,
  output drv_t drv,
  output logic mon_rst_req,
  output logic flag_set,
  output logic ie_lat,
  output logic qual_en
);
  st_e   st_q, st_d;
  resp_e resp_q;
  logic  ie_q, stop_prev_q, mon_rst_q;
  drv_t  drv_q;
  logic  stop_rise, leave_stop, lost, rst_pulse;

  assign stop_rise  = stop_mode && !stop_prev_q;
  assign leave_stop = wake_evt || ext_rst;
  assign lost       = osc_fail && (resp_q == RESP_BACKUP);

  always_comb begin
    st_d      = st_q;
    flag_set  = 1'b0;
    rst_pulse = 1'b0;
    case (st_q)
      S_RUN: if (stop_rise) st_d = S_WATCH;
      S_WATCH: begin
        if (osc_fail && resp_q == RESP_RESET) begin
          rst_pulse = 1'b1;
          st_d      = S_RUN;
        end else if (lost) begin
          flag_set = 1'b1;
          st_d     = S_BK_STOP;
        end else if (leave_stop) begin
          st_d = S_RUN;
        end
      end
      S_BK_STOP: begin
        if (qual_done)                  st_d = leave_stop ? S_RUN : S_PLL_DOWN;
        else if (leave_stop || irq_in)  st_d = S_BK_RUN;
      end
      S_PLL_DOWN, S_QUIET: begin
        if (lost) begin
          flag_set = 1'b1;
          st_d     = S_BK_STOP;
        end else if (leave_stop) begin
          st_d = S_RUN;
        end else begin
          st_d = S_QUIET;
        end
      end
      S_BK_RUN: if (qual_done) st_d = S_RUN;
      default: st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_RUN;
      resp_q      <= RESP_NONE;
      ie_q        <= 1'b0;
      stop_prev_q <= 1'b0;
      mon_rst_q   <= 1'b0;
      drv_q       <= drive_of(S_RUN);
    end else begin
      st_q        <= st_d;
      stop_prev_q <= stop_mode;
      mon_rst_q   <= rst_pulse;
      drv_q       <= drive_of(st_d);
      if (st_q == S_RUN && stop_rise) begin
        resp_q <= resp_of(cfg_mon_en, cfg_scm_en);
        ie_q   <= cfg_scm_ie;
      end
    end
  end

  assign drv         = drv_q;
  assign mon_rst_req = mon_rst_q;
  assign ie_lat      = ie_q;
  assign qual_en     = (st_q == S_BK_STOP) || (st_q == S_BK_RUN);

  // R3: reset request lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mon_rst_q |=> !mon_rst_q);

  // R10: the PLL is released as system clock only after qualification
  a_r10_release_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_q.sel_pll) |-> $past(qual_done || rst));

endmodule

// File: rtl/osc_loss_supervisor.sv
module osc_loss_supervisor
  import osc_loss_pkg::*;
#(
  parameter int QUAL_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_mon_en,
  input  logic cfg_scm_en,
  input  logic cfg_scm_ie,
  input  logic osc_fail,
  input  logic osc_edge,
  input  logic stop_mode,
  input  logic wake_evt,
  input  logic ext_rst,
  input  logic flag_clr,
  output logic mon_rst_req,
  output logic vreg_en,
  output logic pll_en,
  output logic scm_active,
  output logic scm_flag,
  output logic scm_irq,
  output logic sysclk_pll
);
  drv_t drv;
  logic flag_set, ie_lat, qual_en, qual_done;

  osc_loss_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop_mode   (stop_mode),
    .wake_evt    (wake_evt),
    .ext_rst     (ext_rst),
    .osc_fail    (osc_fail),
    .cfg_mon_en  (cfg_mon_en),
    .cfg_scm_en  (cfg_scm_en),
    .cfg_scm_ie  (cfg_scm_ie),
    .qual_done   (qual_done),
    .irq_in      (scm_irq),
    .drv         (drv),
    .mon_rst_req (mon_rst_req),
    .flag_set    (flag_set),
    .ie_lat      (ie_lat),
    .qual_en     (qual_en)
  );

  osc_qual_counter #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .en       (qual_en),
    .osc_edge (osc_edge),
    .osc_fail (osc_fail),
    .done     (qual_done)
  );

  osc_loss_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (flag_set),
    .clr  (flag_clr),
    .ie   (ie_lat),
    .flag (scm_flag),
    .irq  (scm_irq)
  );

  assign vreg_en    = drv.vreg;
  assign pll_en     = drv.pll;
  assign scm_active = drv.scm;
  assign sysclk_pll = drv.sel_pll;

  // R4: entering self-clock operation always leaves the flag set
  a_r4_flag_with_scm: assert property (@(posedge clk) disable iff (rst)
    $rose(scm_active) |-> scm_flag);

  // R2: a reset request never coincides with self-clock operation
  a_r2_rst_excl_scm: assert property (@(posedge clk) disable iff (rst)
    mon_rst_req |-> !scm_active && !pll_en);

endmodule

// File: tb/sim_osc_loss_supervisor.sv
`timescale 1ns/1ps
module sim_osc_loss_supervisor;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, mon, bk, ie, fail, edge_s, stop, wake, xrst, clr;
  logic rreq, vreg, pll, scm, flag, irq, sel;
  int total = 0, bad = 0;
  bit finished = 0;

  osc_loss_supervisor #(.QUAL_CYC(N)) u0 (
    .clk(clk), .rst(rst), .cfg_mon_en(mon), .cfg_scm_en(bk), .cfg_scm_ie(ie),
    .osc_fail(fail), .osc_edge(edge_s), .stop_mode(stop), .wake_evt(wake),
    .ext_rst(xrst), .flag_clr(clr), .mon_rst_req(rreq), .vreg_en(vreg),
    .pll_en(pll), .scm_active(scm), .scm_flag(flag), .scm_irq(irq),
    .sysclk_pll(sel)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string r, logic a, logic e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", r, a, e);
    end
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin edge_s = 1'b1; step(); end
    edge_s = 1'b0;
  endtask

  task automatic enter_stop(logic m, logic b, logic e);
    mon = m; bk = b; ie = e;
    stop = 1'b1; step(); stop = 1'b0;
  endtask

  task automatic pulse_fail();  fail = 1'b1; step(); fail = 1'b0; endtask
  task automatic pulse_wake();  wake = 1'b1; step(); wake = 1'b0; endtask
  task automatic pulse_xrst();  xrst = 1'b1; step(); xrst = 1'b0; endtask
  task automatic pulse_clr();   clr  = 1'b1; step(); clr  = 1'b0; endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    rst = 1; mon = 0; bk = 0; ie = 0; fail = 0; edge_s = 0;
    stop = 0; wake = 0; xrst = 0; clr = 0;
    step(); step(); rst = 0; step();

    // R1 reset state
    chk("R1 vreg", vreg, 1); chk("R1 pll", pll, 0); chk("R1 scm", scm, 0);
    chk("R1 sel", sel, 0); chk("R1 rreq", rreq, 0); chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);

    // sweep all configurations: R2 R3 R4 R5
    for (int c = 0; c < 8; c++) begin
      logic m, b, e, rmode, bmode;
      m = c[2]; b = c[1]; e = c[0];
      rmode = m & ~b; bmode = m & b;
      enter_stop(m, b, e);
      chk("R2 stop vreg", vreg, 0);
      pulse_fail();
      chk("R3 rreq", rreq, rmode);
      chk("R4 scm", scm, bmode);
      chk("R4 pll", pll, bmode);
      chk("R4 vreg", vreg, rmode | bmode);
      chk("R4 flag", flag, bmode);
      chk("R4 sel", sel, 0);
      chk("R5 irq", irq, bmode & e);
      step();
      chk("R3 rreq single", rreq, 0);
      chk("R5 sel after irq", sel, bmode & e);
      chk("R2 no flag", flag, bmode);
      pulse_wake();
      strobe(N); step();
      chk("R10 back to run sel", sel, 0);
      chk("R10 back to run pll", pll, 0);
      chk("R9 run vreg", vreg, 1);
      pulse_clr();
      chk("R11 cleared", flag, 0);
    end

    // R6 R7 R8 R9 R11: recovery inside stop with a restart
    enter_stop(1, 1, 0);
    pulse_fail();
    step(); step(); step();
    chk("R6 still stopped", sel, 0);
    chk("R6 scm held", scm, 1);
    chk("R5 irq gated", irq, 0);
    strobe(5);
    pulse_fail();
    strobe(N - 1); step();
    chk("R7 restart pll", pll, 1);
    strobe(1);
    chk("R7 done edge pll", pll, 1);
    step();
    chk("R8 pll off", pll, 0);
    chk("R8 scm off", scm, 0);
    chk("R8 vreg held", vreg, 1);
    step();
    chk("R8 vreg off", vreg, 0);
    chk("R11 flag sticky", flag, 1);
    pulse_wake();
    chk("R9 wake vreg", vreg, 1);
    chk("R9 wake sel", sel, 0);
    chk("R9 wake pll", pll, 0);
    clr = 1; fail = 0; step(); clr = 0;
    chk("R11 clear", flag, 0);

    // R6 R10: external reset before recovery leaves on PLL
    enter_stop(1, 1, 0);
    pulse_fail();
    pulse_xrst();
    chk("R6 xrst sel", sel, 1);
    strobe(N - 1); step();
    chk("R10 not yet", sel, 1);
    strobe(1); step();
    chk("R10 released", sel, 0);
    chk("R10 pll", pll, 0);
    pulse_clr();

    // R9: external reset after recovery leaves on oscillator
    enter_stop(1, 1, 0);
    pulse_fail();
    strobe(N); step(); step();
    chk("R9 quiet vreg", vreg, 0);
    pulse_xrst();
    chk("R9 xrst vreg", vreg, 1);
    chk("R9 xrst sel", sel, 0);
    pulse_clr();

    // R12: configuration changed during stop is ignored
    enter_stop(0, 0, 0);
    mon = 1; bk = 1; ie = 1;
    pulse_fail();
    chk("R12 scm", scm, 0);
    chk("R12 rreq", rreq, 0);
    chk("R12 flag", flag, 0);
    pulse_wake();
    chk("R12 run vreg", vreg, 1);

    summary();
  end
endmodule